// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit segment:offset logical address into a 20-bit physical address for a small 16-bit processor. It keeps four 16-bit segment registers: code, stack, data and extra. A write port loads them. For each request the block picks a segment from the access kind and the base register that the address came from, shifts that segment left by four bits and adds the offset. The sum wraps within the 1 MB physical space. Each segment therefore opens a 64 KB window into memory.

A requester can force the segment with an override input. A far-pointer request carries its own segment value on a separate input, so it does not use the stored registers. The result is registered and appears one clock after the request. After reset the code segment holds 0xF000, so a fetch at offset 0xFFF0 reaches physical address 0xFFFF0.

Top module: `seg_xlate`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. Any carry out of bit 19 is dropped.
- R2: A fetch request (kind code 0) with no valid override uses the code segment (select code 0).
- R3: A data request (kind code 1) whose base tag names the stack pointer (tag 1) or the frame pointer (tag 2), with no valid override, uses the stack segment (select code 1).
- R4: A data request whose base tag is 0 or 3, with no valid override, uses the data segment (select code 2).
- R5: A string-destination request (kind code 2) always uses the extra segment (select code 3). A valid override has no effect on it.
- R6: When the override is valid, a fetch or a data request uses the segment named by the override select (codes as in R2 to R5). The base tag is then ignored.
- R7: A far request (kind code 3) uses the far-segment input as its segment. The stored registers and any override are ignored.
- R8: A write loads the chosen register with the write value. A request in the same cycle still sees the old value. Requests from the next cycle see the new value.
- R9: Reset sets the code segment to 0xF000, clears the other three segments and drops the response valid. A fetch at offset 0xFFF0 then yields 0xFFFF0.
- R10: The response valid is high exactly one cycle after each accepted request, and low otherwise. While no request is made, the response address keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load a segment register |
| wr_sel | input | 2 | Register to load (0 code, 1 stack, 2 data, 3 extra) |
| wr_value | input | 16 | Value to load |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | 0 fetch, 1 data, 2 string destination, 3 far |
| req_base | input | 2 | Base tag: 0 other, 1 stack pointer, 2 frame pointer, 3 other |
| req_offset | input | 16 | Logical offset |
| ovr_valid | input | 1 | Override is present |
| ovr_sel | input | 2 | Segment forced by the override |
| far_seg | input | 16 | Segment value for a far request |
| rsp_valid | output | 1 | Physical address valid |
| rsp_addr | output | 20 | Physical address |

## Verification
The assertions check on every cycle that the response follows a request by exactly one cycle and that the address holds when no request is made. They also check that a far request produces the shifted far segment plus the offset, with wraparound, and that reset clears the response. Segment selection cannot be checked that way: which register is chosen, override priority, the exemption for the string destination and write-versus-read ordering in the same cycle all depend on stored register contents. Only the bench's scenarios show these, by loading known segment values and comparing the translated addresses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_sel_e;

  typedef enum logic [1:0] {
    ACC_FETCH   = 2'd0,
    ACC_DATA    = 2'd1,
    ACC_STR_DST = 2'd2,
    ACC_FAR     = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    BASE_OTHER = 2'd0,
    BASE_SP    = 2'd1,
    BASE_BP    = 2'd2,
    BASE_ALT   = 2'd3
  } base_tag_e;

  localparam int NSEG = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W      = 16,
  parameter int NREG       = 4,
  parameter logic [15:0] CODE_RESET = 16'hF000,
  localparam int SEL_W     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_value,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_value
);
  logic [SEG_W-1:0] seg_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    // Register 0 is the code segment and gets the boot value.
    localparam logic [SEG_W-1:0] RST_VAL = (i == 0) ? SEG_W'(CODE_RESET) : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q[i] <= RST_VAL;
      end else if (wr_en && wr_sel == SEL_W'(i)) begin
        seg_q[i] <= wr_value;
      end
    end
  end

  assign rd_value = seg_q[rd_sel];
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_xlate_pkg::*;
(
  input  acc_kind_e kind,
  input  base_tag_e base,
  input  logic      ovr_valid,
  input  seg_sel_e  ovr_sel,
  output seg_sel_e  sel,
  output logic      use_far
);
  always_comb begin
    use_far = (kind == ACC_FAR);
    sel     = SEG_DATA;
    unique case (kind)
      ACC_STR_DST: sel = SEG_EXTRA;
      ACC_FETCH:   sel = ovr_valid ? ovr_sel : SEG_CODE;
      ACC_DATA: begin
        if (ovr_valid)                              sel = ovr_sel;
        else if (base == BASE_SP || base == BASE_BP) sel = SEG_STACK;
        else                                        sel = SEG_DATA;
      end
      ACC_FAR:     sel = SEG_DATA;
    endcase
  end
endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  // Sum kept at PA_W bits: the carry out of the top bit is dropped.
  assign pa = {seg, {SHIFT{1'b0}}} + PA_W'(off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [15:0] CODE_RESET = 16'hF000,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_value,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_base,
  input  logic [OFF_W-1:0] req_offset,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] far_seg,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_addr
);
  seg_sel_e         sel;
  logic             use_far;
  logic [SEG_W-1:0] reg_seg;
  logic [SEG_W-1:0] eff_seg;
  logic [PA_W-1:0]  pa;

  seg_select u_sel (
    .kind      (acc_kind_e'(req_kind)),
    .base      (base_tag_e'(req_base)),
    .ovr_valid (ovr_valid),
    .ovr_sel   (seg_sel_e'(ovr_sel)),
    .sel       (sel),
    .use_far   (use_far)
  );

  seg_regfile #(
    .SEG_W      (SEG_W),
    .NREG       (NSEG),
    .CODE_RESET (CODE_RESET)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_value (wr_value),
    .rd_sel   (sel),
    .rd_value (reg_seg)
  );

  assign eff_seg = use_far ? far_seg : reg_seg;

  seg_addr_add #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
  ) u_add (
    .seg (eff_seg),
    .off (req_offset),
    .pa  (pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_addr <= pa;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [OFF_W-1:0] req_offset,
  input logic [SEG_W-1:0] far_seg,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_addr
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !rsp_valid);

  // R7 and R1: far segment shifted plus offset, wrapped to PA_W bits.
  a_r7_far_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=>
      rsp_addr == PA_W'({$past(far_seg), {SHIFT{1'b0}}} + PA_W'($past(req_offset))));
endmodule

bind seg_xlate seg_xlate_chk #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .SHIFT (SHIFT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_offset (req_offset),
  .far_seg    (far_seg),
  .rsp_valid  (rsp_valid),
  .rsp_addr   (rsp_addr)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_value;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [1:0]  req_base;
  logic [15:0] req_offset;
  logic        ovr_valid;
  logic [1:0]  ovr_sel;
  logic [15:0] far_seg;
  logic        rsp_valid;
  logic [19:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_value(wr_value),
    .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
    .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .far_seg(far_seg), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
  );

  // {req_id[3:0], kind[1:0], base[1:0], ovr_v, ovr_s[1:0], off[15:0], far[15:0], exp[19:0]}
  localparam int NV = 11;
  localparam logic [62:0] VEC [NV] = '{
    {4'd2,  2'd0, 2'd0, 1'b0, 2'd0, 16'h0010, 16'h0000, 20'h12350}, // R2 fetch, code seg
    {4'd3,  2'd1, 2'd1, 1'b0, 2'd0, 16'h0100, 16'h0000, 20'h20100}, // R3 stack pointer base
    {4'd3,  2'd1, 2'd2, 1'b0, 2'd0, 16'hFFFF, 16'h0000, 20'h2FFFF}, // R3 frame pointer base
    {4'd4,  2'd1, 2'd0, 1'b0, 2'd0, 16'h0004, 16'h0000, 20'h30004}, // R4 other base
    {4'd4,  2'd1, 2'd3, 1'b0, 2'd0, 16'h0008, 16'h0000, 20'h30008}, // R4 tag 3
    {4'd5,  2'd2, 2'd0, 1'b1, 2'd0, 16'h0020, 16'h0000, 20'h00010}, // R5 override ignored, R1 wrap
    {4'd5,  2'd2, 2'd1, 1'b0, 2'd0, 16'h000F, 16'h0000, 20'hFFFFF}, // R5 extra seg
    {4'd6,  2'd1, 2'd1, 1'b1, 2'd3, 16'h0001, 16'h0000, 20'hFFFF1}, // R6 data forced to extra
    {4'd6,  2'd0, 2'd0, 1'b1, 2'd2, 16'h0002, 16'h0000, 20'h30002}, // R6 fetch forced to data
    {4'd7,  2'd3, 2'd0, 1'b1, 2'd1, 16'h1234, 16'hABCD, 20'hACF04}, // R7 far, override ignored
    {4'd1,  2'd3, 2'd0, 1'b0, 2'd0, 16'hFFFF, 16'hFFFF, 20'h0FFEF}  // R1 far wrap
  };

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_value = 0; req_valid = 0; req_kind = 0; req_base = 0;
    req_offset = 0; ovr_valid = 0; ovr_sel = 0; far_seg = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); idle(); wr_en = 1; wr_sel = s; wr_value = v;
    @(negedge clk); idle();
  endtask

  task automatic req(input logic [1:0] k, input logic [1:0] b, input logic ov,
                     input logic [1:0] os, input logic [15:0] off, input logic [15:0] fs);
    req_valid = 1; req_kind = k; req_base = b; ovr_valid = ov; ovr_sel = os;
    req_offset = off; far_seg = fs;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R9 rsp_valid after reset", {19'd0, rsp_valid}, 20'd0);
    // R9 boot fetch
    @(negedge clk); req(2'd0, 2'd0, 1'b0, 2'd0, 16'hFFF0, 16'h0);
    @(negedge clk); idle();
    check("R9 boot fetch", rsp_addr, 20'hFFFF0);
    check("R10 valid after request", {19'd0, rsp_valid}, 20'd1);
    // R9 stack segment cleared
    req(2'd1, 2'd2, 1'b0, 2'd0, 16'h0010, 16'h0);
    @(negedge clk); idle();
    check("R9 stack seg zero", rsp_addr, 20'h00010);

    wr(2'd0, 16'h1234); wr(2'd1, 16'h2000); wr(2'd2, 16'h3000); wr(2'd3, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req(VEC[i][58:57], VEC[i][56:55], VEC[i][54], VEC[i][53:52], VEC[i][51:36], VEC[i][35:20]);
      @(negedge clk); idle();
      check($sformatf("R%0d vector %0d", VEC[i][62:59], i), rsp_addr, VEC[i][19:0]);
      check($sformatf("R10 valid vector %0d", i), {19'd0, rsp_valid}, 20'd1);
    end

    // R8: write and request in the same cycle
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd2; wr_value = 16'h4000;
    req(2'd1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h0);
    @(negedge clk); idle();
    check("R8 same-cycle old value", rsp_addr, 20'h30000);
    req(2'd1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h0);
    @(negedge clk); idle();
    check("R8 next-cycle new value", rsp_addr, 20'h40000);

    // R10: idle holds address, valid drops
    @(negedge clk);
    check("R10 idle valid low", {19'd0, rsp_valid}, 20'd0);
    check("R10 idle address held", rsp_addr, 20'h40000);

    // R9: reset again restores code segment
    rst = 1; @(negedge clk); rst = 0;
    check("R9 valid cleared by reset", {19'd0, rsp_valid}, 20'd0);
    req(2'd0, 2'd0, 1'b0, 2'd0, 16'hFFF0, 16'h0);
    @(negedge clk); idle();
    check("R9 code seg restored", rsp_addr, 20'hFFFF0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule